// File: doc/BRIEF.md
# Wide-Word Pixel Unpacker

This block sits between a 32-bit pixel bus and a colour look-up stage. It accepts one 32-bit word per load and hands out one pixel per pixel-clock cycle. A mode input sets the packing of each word: one 24-bit pixel, two 16-bit pixels, four 8-bit pixels, eight 4-bit pixels or thirty-two 1-bit pixels. Pixels are always taken from the low end of the word first.

The unpacker controls the timing of the stream. It raises a load strobe in the cycle where it can accept the next word, so loads come at the pixel rate divided by the number of pixels per word. The word source uses this strobe to pace itself. One cycle before a multiplexed word's last pixel, the block also pulses a shift-clock enable so the source can move its serial data along. The mode is read only when a word is accepted, so a mode change takes effect at a word boundary. If the stream runs dry at a word boundary, the block drops its pixel-valid output and raises a sticky underrun flag.

Top module: `pix_unpacker`

## Requirements
- R1: Mode code 0 selects 24 bits per pixel. Each accepted word gives exactly one pixel, equal to word bits 23:0, and bits 31:24 are ignored.
- R2: Mode code 1 selects 16 bits per pixel. Each word gives two pixels, bits 15:0 first and then bits 31:16. A load is requested every second cycle during a continuous stream.
- R3: Mode code 2 selects 8 bits per pixel. Each word gives four pixels, bits 7:0 first and then upwards in 8-bit steps. A load is requested every fourth cycle.
- R4: Mode code 3 gives eight 4-bit pixels per word, starting at bits 3:0. Mode code 4 gives thirty-two 1-bit pixels per word, starting at bit 0. Each pixel is zero-extended to 24 bits.
- R5: Mode codes 5, 6 and 7 behave exactly like mode code 0.
- R6: load_o is high when the block is idle and in the cycle that presents a word's last pixel.
  - A word is accepted on a clock edge where both load_o and word_valid_i are high.
  - Its first pixel is on pix_o, with pix_valid_o high, in the following cycle.
  - Back-to-back words stream with no gap cycle.
- R7: mode_i is sampled only when a word is accepted. Changing it while a word is being emitted does not affect that word's pixels.
- R8: In modes with more than one pixel per word, shift_o is high for exactly one cycle per word. That cycle is the one before the last pixel, so the next cycle has load_o high. In one-pixel modes, shift_o is high in every cycle that presents a pixel.
- R9: If the last pixel of a word is presented and word_valid_i is low, pix_valid_o is low in the next cycle and underrun_o goes high. underrun_o then stays high until reset. Waiting idle before the first word does not set underrun_o.
- R10: While reset is asserted, and while idle after it, pix_valid_o, pix_o, shift_o and underrun_o are 0 and load_o is 1. pix_o is 0 in every cycle where pix_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Packing mode code, sampled when a word is accepted |
| word_i | input | 32 | Packed pixel word from the wide bus |
| word_valid_i | input | 1 | word_i holds a word ready to be loaded |
| load_o | output | 1 | Load strobe: the block can accept a word this cycle |
| shift_o | output | 1 | Shift-clock enable for the word source |
| pix_o | output | 24 | Current pixel, zero-extended |
| pix_valid_o | output | 1 | pix_o holds a pixel |
| underrun_o | output | 1 | Sticky flag: the stream ran dry at a word boundary |

## Verification
A continuous stream visits every packing mode. The words are chosen so that a swapped nibble, byte or half-word order changes the visible pixels. A set top byte in 24-bit mode checks that bits 31:24 are discarded. The bench moves mode_i to the next word's mode while the current word is still being emitted, which catches any decoder that reads the live mode instead of the latched one. Checking load_o and shift_o cycle by cycle across several packing ratios separates a correct divide ratio from an off-by-one strobe position. Separate directed runs cover three cases: the stream ending at a word boundary (underrun), idle waiting (no underrun) and a reserved mode code.

// File: rtl/pix_unpacker_pkg.sv
package pix_unpacker_pkg;

  localparam logic [2:0] MODE_D24 = 3'd0;
  localparam logic [2:0] MODE_D16 = 3'd1;
  localparam logic [2:0] MODE_D8  = 3'd2;
  localparam logic [2:0] MODE_D4  = 3'd3;
  localparam logic [2:0] MODE_D1  = 3'd4;

  // Pixels carried by one 32-bit word for a given mode code
  function automatic logic [5:0] pix_per_word(input logic [2:0] mode);
    unique case (mode)
      MODE_D16: pix_per_word = 6'd2;
      MODE_D8:  pix_per_word = 6'd4;
      MODE_D4:  pix_per_word = 6'd8;
      MODE_D1:  pix_per_word = 6'd32;
      default:  pix_per_word = 6'd1;
    endcase
  endfunction

endpackage

// File: rtl/pxu_seq.sv
module pxu_seq
  import pix_unpacker_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode_i,
  input  logic             word_valid_i,
  output logic             load_o,
  output logic             shift_o,
  output logic             take_o,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [2:0]       mode_o,
  output logic             underrun_o
);

  logic             busy_q, busy_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [2:0]       mode_q, mode_d;
  logic             urun_q, urun_d;
  logic [5:0]       ppw;
  logic [5:0]       idx_ext;
  logic             last;
  logic             take;

  always_comb begin
    ppw     = pix_per_word(mode_q);
    idx_ext = 6'(idx_q);
    last    = busy_q && (idx_ext == ppw - 6'd1);
    load_o  = !busy_q || last;
    take    = load_o && word_valid_i;
    if (ppw == 6'd1) shift_o = busy_q;
    else             shift_o = busy_q && (idx_ext == ppw - 6'd2);
  end

  // next-state process
  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    mode_d = mode_q;
    urun_d = urun_q | (last && !word_valid_i);
    if (take) begin
      busy_d = 1'b1;
      idx_d  = '0;
      mode_d = mode_i;
    end else if (last) begin
      busy_d = 1'b0;
      idx_d  = '0;
    end else if (busy_q) begin
      idx_d  = idx_q + 1'b1;
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      mode_q <= MODE_D24;
      urun_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      mode_q <= mode_d;
      urun_q <= urun_d;
    end
  end

  assign take_o     = take;
  assign busy_o     = busy_q;
  assign idx_o      = idx_q;
  assign mode_o     = mode_q;
  assign underrun_o = urun_q;

  // R6
  take_starts_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_o && word_valid_i) |=> (busy_q && idx_q == '0));

  // R7
  mode_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !take) |=> $stable(mode_q));

  // R8
  shift_then_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_o && ppw != 6'd1) |=> load_o);

  // R9
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |=> underrun_o);

  // R9
  dry_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && load_o && !word_valid_i) |=> (!busy_q && underrun_o));

  // R4
  idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (idx_ext < ppw));

endmodule

// File: rtl/pxu_lane.sv
module pxu_lane
  import pix_unpacker_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int PIX_W  = 24,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [2:0]        mode_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              valid_i,
  output logic [PIX_W-1:0]  pix_o
);

  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  amt;
  logic [WORD_W-1:0] shifted;
  logic [PIX_W-1:0]  ext;

  // word register with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word_q <= '0;
    else if (take_i) word_q <= word_i;
  end

  always_comb begin
    unique case (mode_i)
      MODE_D16: amt = idx_i << 4;
      MODE_D8:  amt = idx_i << 3;
      MODE_D4:  amt = idx_i << 2;
      MODE_D1:  amt = idx_i;
      default:  amt = '0;
    endcase
    shifted = word_q >> amt;
    unique case (mode_i)
      MODE_D16: ext = PIX_W'(shifted[15:0]);
      MODE_D8:  ext = PIX_W'(shifted[7:0]);
      MODE_D4:  ext = PIX_W'(shifted[3:0]);
      MODE_D1:  ext = PIX_W'(shifted[0]);
      default:  ext = shifted[PIX_W-1:0];
    endcase
    pix_o = valid_i ? ext : '0;
  end

  // R1
  top_byte_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && (mode_i == MODE_D24)) |-> (pix_o == word_q[PIX_W-1:0]));

endmodule

// File: rtl/pix_unpacker.sv
module pix_unpacker
  import pix_unpacker_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int PIX_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_valid_i,
  output logic              load_o,
  output logic              shift_o,
  output logic [PIX_W-1:0]  pix_o,
  output logic              pix_valid_o,
  output logic              underrun_o
);

  localparam int IDX_W = $clog2(WORD_W);

  logic             take;
  logic             busy;
  logic [IDX_W-1:0] idx;
  logic [2:0]       mode_q;

  pxu_seq #(.IDX_W(IDX_W)) seq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_i),
    .word_valid_i (word_valid_i),
    .load_o       (load_o),
    .shift_o      (shift_o),
    .take_o       (take),
    .busy_o       (busy),
    .idx_o        (idx),
    .mode_o       (mode_q),
    .underrun_o   (underrun_o)
  );

  pxu_lane #(.WORD_W(WORD_W), .PIX_W(PIX_W), .IDX_W(IDX_W)) lane_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .take_i  (take),
    .word_i  (word_i),
    .mode_i  (mode_q),
    .idx_i   (idx),
    .valid_i (busy),
    .pix_o   (pix_o)
  );

  assign pix_valid_o = busy;

endmodule

// File: tb/pix_unpacker_tb_top.sv
`timescale 1ns/1ps
module pix_unpacker_tb_top;

  logic        clk;
  logic        rst_n;
  logic [2:0]  mode_i;
  logic [31:0] word_i;
  logic        word_valid_i;
  logic        load_o, shift_o, pix_valid_o, underrun_o;
  logic [23:0] pix_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  pix_unpacker dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .word_i(word_i),
    .word_valid_i(word_valid_i), .load_o(load_o), .shift_o(shift_o),
    .pix_o(pix_o), .pix_valid_o(pix_valid_o), .underrun_o(underrun_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // stimulus table: {mode code, packed word}
  localparam int NV = 9;
  localparam logic [34:0] TBL [NV] = '{
    {3'd0, 32'hFFA1B2C3},
    {3'd1, 32'h1234ABCD},
    {3'd2, 32'h80402010},
    {3'd3, 32'hFEDCBA98},
    {3'd4, 32'hA5A50F01},
    {3'd2, 32'h000000FF},
    {3'd1, 32'hFFFF0001},
    {3'd0, 32'h00123456},
    {3'd3, 32'h76543210}
  };

  function automatic int ref_ppw(input logic [2:0] m);
    case (m)
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd4: return 32;
      default: return 1;
    endcase
  endfunction

  function automatic logic [23:0] ref_pix(input logic [31:0] w, input logic [2:0] m, input int i);
    logic [23:0] r;
    int bits;
    r = '0;
    bits = (ref_ppw(m) == 1) ? 24 : 32 / ref_ppw(m);
    for (int b = 0; b < bits; b++) r[b] = w[i*bits + b];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    word_valid_i = 1'b0;
    mode_i = 3'd0;
    word_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic loaded, active;
    logic [31:0] cur_w;
    logic [2:0]  cur_m;
    int cur_i, k, np;

    rst_n = 1'b0; word_valid_i = 1'b0; mode_i = '0; word_i = '0;
    @(negedge clk);
    // R10 outputs during reset
    check("R10 reset pix_valid", 32'(pix_valid_o), 0);
    check("R10 reset load", 32'(load_o), 1);
    check("R10 reset shift", 32'(shift_o), 0);
    check("R10 reset underrun", 32'(underrun_o), 0);
    check("R10 reset pix", 32'(pix_o), 0);
    do_reset();

    // R9 idle waiting is not underrun
    repeat (5) @(negedge clk);
    check("R9 idle no underrun", 32'(underrun_o), 0);
    check("R10 idle load", 32'(load_o), 1);
    check("R10 idle pix_valid", 32'(pix_valid_o), 0);

    // main table walk: continuous stream, mode_i moves on after each accept (R7)
    k = 0; active = 0; cur_i = 0; cur_w = '0; cur_m = '0;
    mode_i = TBL[0][34:32]; word_i = TBL[0][31:0]; word_valid_i = 1'b1;
    loaded = load_o && word_valid_i;
    for (int cyc = 0; cyc < 2000; cyc++) begin
      @(negedge clk);
      if (loaded) begin
        cur_m = TBL[k][34:32]; cur_w = TBL[k][31:0]; cur_i = 0; active = 1; k++;
        if (k < NV) begin
          mode_i = TBL[k][34:32]; word_i = TBL[k][31:0];
        end else begin
          word_valid_i = 1'b0; mode_i = 3'd7; word_i = 32'hDEADBEEF;
        end
      end else if (active) begin
        if (cur_i == ref_ppw(cur_m) - 1) active = 0;
        else cur_i++;
      end
      if (!active) break;
      np = ref_ppw(cur_m);
      // R1 R2 R3 R4 pixel order and width; R6 no gap; R7 latched mode
      check($sformatf("R1-4/R6/R7 pix_valid m%0d i%0d", cur_m, cur_i), 32'(pix_valid_o), 1);
      check($sformatf("R1 R2 R3 R4 pix m%0d i%0d", cur_m, cur_i), 32'(pix_o), 32'(ref_pix(cur_w, cur_m, cur_i)));
      check($sformatf("R6 load m%0d i%0d", cur_m, cur_i), 32'(load_o), 32'(cur_i == np - 1));
      check($sformatf("R8 shift m%0d i%0d", cur_m, cur_i), 32'(shift_o),
            32'((np == 1) ? 1'b1 : (cur_i == np - 2)));
      check("R9 no underrun while fed", 32'(underrun_o), 0);
      loaded = load_o && word_valid_i;
    end
    check("R6 all words consumed", 32'(k), NV);

    // R9 stream ran dry at a word boundary
    check("R9 pix_valid low after dry", 32'(pix_valid_o), 0);
    check("R9 underrun set", 32'(underrun_o), 1);
    check("R10 pix zero when invalid", 32'(pix_o), 0);
    repeat (4) @(negedge clk);
    check("R9 underrun sticky", 32'(underrun_o), 1);

    // R10 reset clears underrun
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 reset clears underrun", 32'(underrun_o), 0);
    do_reset();

    // R5 reserved mode code acts as 24-bit
    mode_i = 3'd6; word_i = 32'hAB123456; word_valid_i = 1'b1;
    @(negedge clk);
    word_valid_i = 1'b0; mode_i = 3'd4;
    check("R5 reserved mode valid", 32'(pix_valid_o), 1);
    check("R5 reserved mode pix", 32'(pix_o), 32'h00123456);
    check("R5 reserved mode load", 32'(load_o), 1);
    check("R5 reserved mode shift", 32'(shift_o), 1);
    @(negedge clk);
    check("R5 single pixel per word", 32'(pix_valid_o), 0);
    check("R9 underrun after reserved word", 32'(underrun_o), 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule